// File: doc/BRIEF.md
# Framed Serial Transmitter

This block turns a byte written by the host logic into an asynchronous serial frame on a single output line. One frame is a low start bit, eight data bits sent least significant bit first, an optional ninth data bit, and a high stop bit. A write strobe loads the whole frame into a shift register. The output latch then takes one bit from the bottom of that register at each bit boundary.

Bit boundaries come from a divide-by-16 counter that advances on an externally generated baud tick. The counter runs freely from reset and a write never restarts it. As a result, the first bit of a frame waits for the next rollover, which can be anywhere up to sixteen ticks away. When the stop bit enters the output latch, a done flag is raised. The flag stays up until the host clears it.

Top module: `sertx_framer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tx_line` is 1 and `tx_done` is 0.
- R2: With `wide_mode`=0, a write sends 10 bits in this order: start 0, then `din[0]` to `din[7]`, then stop 1. `ninth_bit` has no effect in this mode.
- R3: With `wide_mode`=1, a write sends 11 bits in this order: start 0, then `din[0]` to `din[7]`, then `ninth_bit`, then stop 1.
- R4: Each bit holds `tx_line` for exactly 16 baud ticks. A new bit is latched only on a counter rollover.
- R5: The tick counter counts ticks since reset and is never reset by a write. The start bit is latched at the first rollover after the write cycle. The latency is therefore 1 to 16 ticks, and the start edge always falls at a tick count that is a multiple of 16.
- R6: When no frame is in progress, `tx_line` is 1. This holds both before the first write and after each stop bit.
- R7: `tx_done` rises in the cycle after the stop bit is latched. It is 0 while the start bit and data bits are on the line.
- R8: `tx_done` stays 1 until `done_clr` is sampled high, and falls in the following cycle. If a set and a clear occur in the same cycle, the set wins.
- R9: A write during a frame abandons the remaining bits and loads the new frame. The bit currently on the line is held until the next rollover, and the new frame's start bit follows it.
- R10: `tx_line` changes only in the cycle after a rollover. A write alone never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle baud clock pulse, 16 per bit |
| wr_strobe | input | 1 | Load `din` and start a frame |
| din | input | DATA_W | Data byte |
| ninth_bit | input | 1 | Ninth data bit, used when `wide_mode`=1 |
| wide_mode | input | 1 | 0: 8 data bits; 1: 9 data bits |
| done_clr | input | 1 | Clears `tx_done` |
| tx_line | output | 1 | Serial output latch |
| tx_done | output | 1 | Frame-complete flag |

## Verification
The bench uses the default configuration: 8 data bits and 16 ticks per bit. This makes every byte value reachable, so all 256 bytes are framed in the 8-bit mode, and every even byte is framed in the 9-bit mode with the ninth bit alternating. Most frames run with a tick on every clock, which keeps the full sweep short. A few frames use a tick every second clock to show that bit length follows ticks rather than clocks. A bench-side count of ticks since reset confirms that every start edge lands on a multiple of 16. The sweep also covers a restart in mid-frame and a flag clear that collides with the flag set.

// File: rtl/sertx_pkg.sv
// Shared helpers for the framed serial transmitter.
// Assumes one start bit, one stop bit and an optional ninth data bit.
package sertx_pkg;

    // Number of bits in one frame for the selected data mode.
    function automatic int frame_bits(input logic wide, input int data_w);
        return data_w + (wide ? 3 : 2);
    endfunction

endpackage

// File: rtl/sertx_baud_div.sv
// Free-running tick divider: counts baud ticks modulo RATIO and pulses
// 'roll' in the cycle whose tick wraps the count to zero.
// Assumes RATIO >= 2. Only reset clears the count.
module sertx_baud_div #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    output logic roll
);
    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [CNT_W-1:0] cnt;

    assign roll = baud_tick && (cnt == CNT_W'(RATIO - 1));

    // Advance the tick count; wrap on the last tick of a bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (roll)
            cnt <= '0;
        else if (baud_tick)
            cnt <= cnt + 1'b1;
    end

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(cnt));

endmodule

// File: rtl/sertx_shift.sv
// Frame shifter: loads start, data, optional ninth and stop bits on a write,
// and moves one bit into the output latch on each rollover, zero-filling
// from the top. 'frame_end' pulses in the cycle the stop bit is latched.
// Assumes 'roll' is a single-cycle pulse. A write takes priority over a shift.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] din,
    input  logic              ninth_bit,
    input  logic              wide_mode,
    output logic              tx_q,
    output logic              frame_end
);
    localparam int SR_W  = DATA_W + 3;
    localparam int LEN_W = $clog2(SR_W + 1);

    logic [SR_W-1:0]  sr;
    logic [LEN_W-1:0] left;
    logic [LEN_W-1:0] full_q;
    logic [SR_W-1:0]  load_val;
    logic [LEN_W-1:0] load_len;

    // Build the frame image: start bit at the bottom, stop bit at the top of the frame.
    always_comb begin
        if (wide_mode)
            load_val = {1'b1, ninth_bit, din, 1'b0};
        else
            load_val = {1'b0, 1'b1, din, 1'b0};
        load_len = LEN_W'(frame_bits(wide_mode, DATA_W));
    end

    assign frame_end = roll && !wr_strobe && (left == LEN_W'(1));

    // Load on a write, otherwise shift one bit out per rollover while bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            left   <= '0;
            full_q <= '0;
            tx_q   <= 1'b1;
        end else if (wr_strobe) begin
            sr     <= load_val;
            left   <= load_len;
            full_q <= load_len;
        end else if (roll && left != '0) begin
            tx_q <= sr[0];
            sr   <= {1'b0, sr[SR_W-1:1]};
            left <= left - 1'b1;
        end
    end

    a_r10_quiet_between_rolls: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(tx_q));
    a_r2_start_goes_first: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && !wr_strobe && left != '0 && left == full_q) |=> !tx_q);
    a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (left == '0) |-> tx_q);
    a_r7_stop_is_high: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> tx_q);
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        left <= LEN_W'(SR_W));

endmodule

// File: rtl/sertx_flag.sv
// Sticky done flag: set by the frame-end pulse, cleared by the host.
// Assumes set takes priority over clear in the same cycle.
module sertx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr,
    output logic done_q
);
    // Hold the flag between a set and the following clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (set_pulse)
            done_q <= 1'b1;
        else if (clr)
            done_q <= 1'b0;
    end

    a_r7_set_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> done_q);
    a_r8_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_pulse) |=> !done_q);
    a_r8_holds_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr) |=> done_q);

endmodule

// File: rtl/sertx_framer.sv
// Framed serial transmitter top: divider, shifter and done flag.
// Assumes baud_tick is a one-cycle pulse produced elsewhere, TICKS_PER_BIT per bit.
module sertx_framer #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] din,
    input  logic              ninth_bit,
    input  logic              wide_mode,
    input  logic              done_clr,
    output logic              tx_line,
    output logic              tx_done
);
    logic roll;
    logic frame_end;

    sertx_baud_div #(.RATIO(TICKS_PER_BIT)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .roll      (roll)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .roll      (roll),
        .wr_strobe (wr_strobe),
        .din       (din),
        .ninth_bit (ninth_bit),
        .wide_mode (wide_mode),
        .tx_q      (tx_line),
        .frame_end (frame_end)
    );

    sertx_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (frame_end),
        .clr       (done_clr),
        .done_q    (tx_done)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (tx_line && !tx_done));

endmodule

// File: tb/sertx_framer_test.sv
module sertx_framer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] din = 8'h00;
    logic       ninth = 1'b0;
    logic       wide = 1'b0;
    logic       clr = 1'b0;
    logic       tx;
    logic       done;

    int nchecks = 0;
    int nerr = 0;
    bit finished = 1'b0;
    int td = 1;
    int tphase = 0;
    int unsigned ticks_seen = 0;

    sertx_framer uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_strobe(wr),
        .din(din), .ninth_bit(ninth), .wide_mode(wide), .done_clr(clr),
        .tx_line(tx), .tx_done(done)
    );

    always #2.5 clk = ~clk;

    // Baud tick: one pulse every td clocks, driven away from the active edge.
    always @(negedge clk) begin
        if (tphase >= td - 1) begin
            baud_tick <= 1'b1;
            tphase <= 0;
        end else begin
            baud_tick <= 1'b0;
            tphase <= tphase + 1;
        end
    end

    // Ticks since reset, counted the way the block should see them.
    always @(posedge clk) begin
        if (!rst_n) ticks_seen <= 0;
        else if (baud_tick) ticks_seen <= ticks_seen + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input bit nb, input bit w);
        @(negedge clk);
        din = d; ninth = nb; wide = w; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Wait for the start edge; check latency and rollover alignment.
    task automatic wait_start(input string req);
        int k = 0;
        while (tx !== 1'b0 && k < 20 * td + 4) begin
            @(negedge clk);
            k++;
        end
        check(k >= 1 && k <= 16 * td, req, "R5 start latency cycles", k, 16 * td);
        check(ticks_seen % 16 == 0, req, "R5 R10 start on rollover, ticks mod 16",
              int'(ticks_seen % 16), 0);
    endtask

    // Sample each bit mid-period after the start has been seen, then test the flag.
    task automatic verify_rest(input logic [7:0] d, input bit nb, input bit w, input string req);
        bit exp_bits[11];
        int n = w ? 11 : 10;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp_bits[i + 1] = d[i];
        exp_bits[9] = w ? nb : 1'b1;
        exp_bits[10] = 1'b1;
        repeat (8 * td) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (16 * td) @(negedge clk);
            check(tx == exp_bits[i], req, $sformatf("R4 bit %0d of byte %0h", i, d),
                  int'(tx), int'(exp_bits[i]));
            if (i == n - 1)
                check(done == 1'b1, req, "R7 done after stop", int'(done), 1);
            else
                check(done == 1'b0, req, "R7 done early", int'(done), 0);
        end
        repeat (16 * td) @(negedge clk);
        check(done == 1'b1, "R8", "done held", int'(done), 1);
        check(tx == 1'b1, "R6", "idle line", int'(tx), 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(done == 1'b0, "R8", "done cleared", int'(done), 0);
    endtask

    task automatic run_frame(input logic [7:0] d, input bit nb, input bit w, input string req);
        write_byte(d, nb, w);
        wait_start(req);
        verify_rest(d, nb, w, req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(tx == 1'b1, "R1", "tx in reset", int'(tx), 1);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx == 1'b1, "R1", "tx after reset", int'(tx), 1);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        repeat (40) @(negedge clk);
        check(tx == 1'b1, "R6", "idle before first write", int'(tx), 1);

        // 8-bit mode, every byte; the ninth input toggles and must not matter.
        for (int d = 0; d < 256; d++)
            run_frame(8'(d), ~d[0], 1'b0, "R2");
        // 9-bit mode, every even byte with the ninth bit alternating.
        for (int d = 0; d < 256; d += 2)
            run_frame(8'(d), d[1], 1'b1, "R3");

        // Slower tick: bit length must follow ticks, not clocks.
        td = 2;
        run_frame(8'hA5, 1'b1, 1'b0, "R4");
        run_frame(8'h3C, 1'b1, 1'b1, "R4");
        td = 1;

        // Restart during a frame.
        write_byte(8'hFF, 1'b0, 1'b0);
        wait_start("R9");
        repeat (8 + 32) @(negedge clk);
        check(tx == 1'b1, "R9", "mid-frame bit", int'(tx), 1);
        write_byte(8'h5A, 1'b0, 1'b0);
        check(tx == 1'b1, "R10", "write leaves line", int'(tx), 1);
        wait_start("R9");
        verify_rest(8'h5A, 1'b0, 1'b0, "R9");

        // Clear colliding with set: the set wins.
        write_byte(8'h33, 1'b1, 1'b1);
        wait_start("R8");
        repeat (160 - 1) @(negedge clk);
        check(done == 1'b0, "R8", "done before stop", int'(done), 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(done == 1'b1, "R8", "set wins over clear", int'(done), 1);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(done == 1'b0, "R8", "later clear", int'(done), 0);

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule